// File: doc/BRIEF.md
# Rotated Immediate Constant Expander

This block turns a compact 12-bit immediate field, taken from a 32-bit instruction word, into a full 32-bit constant. It also produces the shifter carry that goes with that constant. A decode stage places it beside the operand path. Each cycle the stage presents an instruction word, an encoding select and the current carry flag. One clock later it receives the expanded constant, the carry-out and a flag that marks encodings whose result is unpredictable.

Two encodings are supported. In the narrow-rotate encoding, an 8-bit value is rotated right by an even amount. In the wide encoding, the field is gathered from three places in the word. It then expands either into one of four byte-replication patterns or into a byte with an implied leading one, rotated right by a 5-bit amount. The two encodings follow different rules for the carry. Nothing else in the instruction word is decoded here.

Top module: `imm_const_expander`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `imm_out`, `carry_out` and `unpredictable` all become 0 on that edge, whatever the other inputs are.
- R2: With `mode` = 0, `imm_out` equals `instr[7:0]` zero-extended to 32 bits and rotated right by 2 × `instr[11:8]`.
- R3: With `mode` = 0, `carry_out` equals `carry_in` when `instr[11:8]` is 0, and equals bit 31 of the expanded constant otherwise.
- R4: With `mode` = 1, the 12-bit field F is {`instr[26]`, `instr[14:12]`, `instr[7:0]`} with F[11] taken from bit 26. All other instruction bits have no effect on any output.
- R5: With `mode` = 1 and F[11:10] = 00, let b = F[7:0]. F[9:8] then selects the constant: 0 gives 0x000000bb, 1 gives 0x00bb00bb, 2 gives 0xbb00bb00 and 3 gives 0xbbbbbbbb.
- R6: In the replication case of R5, `carry_out` equals `carry_in`.
- R7: With `mode` = 1 and F[11:10] ≠ 00, `imm_out` is (0x80 | F[6:0]) rotated right by F[11:7], and `carry_out` is bit 31 of that constant.
- R8: `unpredictable` is 1 only for `mode` = 1 with F[11:10] = 00, F[9:8] ≠ 0 and F[7:0] = 0. In every other case it is 0, including every `mode` = 0 input.
- R9: All outputs are registered. `out_valid` on each edge takes the value `in_valid` had before that edge. When `in_valid` is 0, `imm_out`, `carry_out` and `unpredictable` keep their previous values.
- R10: With `mode` = 0, `instr[31:12]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request: capture an expansion this cycle |
| instr | input | 32 | Instruction word holding the immediate field |
| mode | input | 1 | Encoding select: 0 narrow-rotate, 1 wide |
| carry_in | input | 1 | Current shifter carry flag |
| out_valid | output | 1 | Registered copy of `in_valid` |
| imm_out | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Shifter carry that goes with the constant |
| unpredictable | output | 1 | Replication pattern with a zero byte was requested |

## Verification
Every one of the 4096 field values is applied in both encodings with both carry-in values, and the unused instruction bits are filled with changing junk. Agreement therefore shows that the field is gathered from the right bits and that the rest are ignored. A table of hand-worked vectors separates the cases that are easy to confuse: rotate amount zero against nonzero, where the carry source changes; each of the four replication patterns, which must not be mixed up with the rotated form; zero-byte patterns, which must raise the unpredictable flag while pattern 0 with a zero byte must not; and the largest wide rotate, which wraps the leading one. Directed steps cover reset taking priority over a valid request, and outputs holding while no request arrives.

// File: rtl/imm_exp_pkg.sv
package imm_exp_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int LANES       = WORD_W / BYTE_W;
    localparam int FIELD_W     = 12;
    localparam int NROT_FLD_W  = 4;
    localparam int ROT_AMT_W   = $clog2(WORD_W);
    localparam int WIDE_TOP_BIT = 26;
    localparam int WIDE_MID_LSB = 12;
    localparam int WIDE_MID_W   = 3;
    localparam int LEAD_W      = BYTE_W - 1;

    typedef enum logic {
        ENC_ROT8 = 1'b0,
        ENC_WIDE = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
        logic              unpred;
    } imm_result_t;

    // Which byte lanes carry the byte for a replication pattern.
    function automatic logic [LANES-1:0] repl_lane_mask(input logic [1:0] pat);
        logic [LANES-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            unique case (pat)
                2'd0:    m[k] = (k == 0);
                2'd1:    m[k] = (k % 2 == 0);
                2'd2:    m[k] = (k % 2 == 1);
                default: m[k] = 1'b1;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/imm_rotr.sv
module imm_rotr #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    // Logarithmic barrel: stage s rotates right by 2**s when amt[s] is set.
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]}
                                   : stage[s];
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/imm_rot8_dec.sv
module imm_rot8_dec
    import imm_exp_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               carry_in,
    output imm_result_t        res
);
    logic [ROT_AMT_W-1:0] amt;
    logic [WORD_W-1:0]    rotated;

    // Rotate amount is the 4-bit field doubled.
    assign amt = {field[BYTE_W +: NROT_FLD_W], 1'b0};

    imm_rotr #(.W(WORD_W), .AMT_W(ROT_AMT_W)) u_rot (
        .din  ({{(WORD_W-BYTE_W){1'b0}}, field[BYTE_W-1:0]}),
        .amt  (amt),
        .dout (rotated)
    );

    always_comb begin
        res.value  = rotated;
        res.carry  = (amt == '0) ? carry_in : rotated[WORD_W-1];
        res.unpred = 1'b0;
    end
endmodule

// File: rtl/imm_wide_dec.sv
module imm_wide_dec
    import imm_exp_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               carry_in,
    output imm_result_t        res
);
    logic [BYTE_W-1:0]    byte_v;
    logic [1:0]           pat;
    logic                 is_repl;
    logic [LANES-1:0]     lane_on;
    logic [WORD_W-1:0]    repl_value;
    logic [WORD_W-1:0]    rot_value;
    logic [ROT_AMT_W-1:0] rot_amt;

    assign byte_v  = field[BYTE_W-1:0];
    assign pat     = field[BYTE_W +: 2];
    assign is_repl = (field[FIELD_W-1 -: 2] == 2'b00);
    assign lane_on = repl_lane_mask(pat);
    assign rot_amt = field[FIELD_W-1 -: ROT_AMT_W];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign repl_value[k*BYTE_W +: BYTE_W] = lane_on[k] ? byte_v : '0;
    end

    imm_rotr #(.W(WORD_W), .AMT_W(ROT_AMT_W)) u_rot (
        .din  ({{(WORD_W-BYTE_W){1'b0}}, 1'b1, field[LEAD_W-1:0]}),
        .amt  (rot_amt),
        .dout (rot_value)
    );

    always_comb begin
        if (is_repl) begin
            res.value  = repl_value;
            res.carry  = carry_in;
            res.unpred = (pat != 2'd0) && (byte_v == '0);
        end else begin
            res.value  = rot_value;
            res.carry  = rot_value[WORD_W-1];
            res.unpred = 1'b0;
        end
    end
endmodule

// File: rtl/imm_const_expander.sv
module imm_const_expander
    import imm_exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic              mode,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] imm_out,
    output logic              carry_out,
    output logic              unpredictable
);
    enc_mode_e          sel;
    logic [FIELD_W-1:0] narrow_field;
    logic [FIELD_W-1:0] wide_field;
    imm_result_t        narrow_res;
    imm_result_t        wide_res;
    imm_result_t        next_res;
    imm_result_t        res_q;
    logic               valid_q;
    logic               unused_instr_bits;

    assign sel          = enc_mode_e'(mode);
    assign narrow_field = instr[FIELD_W-1:0];
    assign wide_field   = {instr[WIDE_TOP_BIT],
                           instr[WIDE_MID_LSB +: WIDE_MID_W],
                           instr[BYTE_W-1:0]};
    assign unused_instr_bits = ^{instr[WORD_W-1:WIDE_TOP_BIT+1],
                                 instr[WIDE_TOP_BIT-1:WIDE_MID_LSB+WIDE_MID_W]};

    imm_rot8_dec u_narrow (
        .field    (narrow_field),
        .carry_in (carry_in),
        .res      (narrow_res)
    );

    imm_wide_dec u_wide (
        .field    (wide_field),
        .carry_in (carry_in),
        .res      (wide_res)
    );

    assign next_res = (sel == ENC_WIDE) ? wide_res : narrow_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= next_res;
            end
        end
    end

    assign out_valid     = valid_q;
    assign imm_out       = res_q.value;
    assign carry_out     = res_q.carry;
    assign unpredictable = res_q.unpred;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(imm_out) && $stable(carry_out)
                       && $stable(unpredictable))); // R9
    AST_NARROW_POP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode) |=>
            ($countones(imm_out) == $countones($past(instr[BYTE_W-1:0])))); // R2
    AST_NARROW_ZERO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode && instr[BYTE_W +: NROT_FLD_W] == '0) |=>
            (carry_out == $past(carry_in))); // R3
    AST_NARROW_MSB_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode && instr[BYTE_W +: NROT_FLD_W] != '0) |=>
            (carry_out == imm_out[WORD_W-1])); // R3
    AST_REPL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode && !instr[WIDE_TOP_BIT]
                  && !instr[WIDE_MID_LSB+WIDE_MID_W-1]) |=>
            (carry_out == $past(carry_in))); // R6
    AST_LEAD_ONE_POP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode && (instr[WIDE_TOP_BIT]
                  || instr[WIDE_MID_LSB+WIDE_MID_W-1])) |=>
            ($countones(imm_out) == $countones($past(instr[LEAD_W-1:0])) + 1)); // R7
    AST_FLAG_NARROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode) |=> !unpredictable); // R8
endmodule

// File: tb/tb_imm_const_expander.sv
module tb_imm_const_expander;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic        mode;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] imm_out;
    logic        carry_out;
    logic        unpredictable;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    imm_const_expander dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .instr         (instr),
        .mode          (mode),
        .carry_in      (carry_in),
        .out_valid     (out_valid),
        .imm_out       (imm_out),
        .carry_out     (carry_out),
        .unpredictable (unpredictable)
    );

    // {mode, carry_in, instr, expected imm, expected carry, expected flag}
    localparam logic [67:0] VEC [0:15] = '{
        {1'b0, 1'b1, 32'h000000FF, 32'h000000FF, 1'b1, 1'b0},
        {1'b0, 1'b0, 32'h000001FF, 32'hC000003F, 1'b1, 1'b0},
        {1'b0, 1'b0, 32'h00000F01, 32'h00000004, 1'b0, 1'b0},
        {1'b0, 1'b1, 32'h00000480, 32'h80000000, 1'b1, 1'b0},
        {1'b0, 1'b0, 32'hABCDE1FF, 32'hC000003F, 1'b1, 1'b0},
        {1'b1, 1'b1, 32'h000000AB, 32'h000000AB, 1'b1, 1'b0},
        {1'b1, 1'b0, 32'h000010AB, 32'h00AB00AB, 1'b0, 1'b0},
        {1'b1, 1'b1, 32'h000020AB, 32'hAB00AB00, 1'b1, 1'b0},
        {1'b1, 1'b0, 32'h000030AB, 32'hABABABAB, 1'b0, 1'b0},
        {1'b1, 1'b1, 32'h00003000, 32'h00000000, 1'b1, 1'b1},
        {1'b1, 1'b0, 32'h00001000, 32'h00000000, 1'b0, 1'b1},
        {1'b1, 1'b0, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
        {1'b1, 1'b0, 32'h00004000, 32'h80000000, 1'b1, 1'b0},
        {1'b1, 1'b1, 32'h040070FF, 32'h000001FE, 1'b0, 1'b0},
        {1'b1, 1'b1, 32'h0400007F, 32'h00FF0000, 1'b0, 1'b0},
        {1'b1, 1'b0, 32'hFBFF8FAB, 32'h000000AB, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Model written from the requirements alone.
    function automatic void model(input logic m, input logic [31:0] w,
                                  input logic cin, output logic [31:0] v,
                                  output logic c, output logic fl);
        logic [31:0] base;
        logic [63:0] dbl;
        logic [11:0] f;
        logic [7:0]  b;
        int          amt;
        fl = 1'b0;
        if (!m) begin
            base = {24'h0, w[7:0]};
            amt  = 2 * int'(w[11:8]);
        end else begin
            f = {w[26], w[14:12], w[7:0]};
            b = f[7:0];
            if (f[11:10] == 2'b00) begin
                case (f[9:8])
                    2'd0:    v = {24'h0, b};
                    2'd1:    v = {8'h0, b, 8'h0, b};
                    2'd2:    v = {b, 8'h0, b, 8'h0};
                    default: v = {b, b, b, b};
                endcase
                c  = cin;
                fl = (f[9:8] != 2'd0) && (b == 8'h0);
                return;
            end
            base = {24'h0, 1'b1, f[6:0]};
            amt  = int'(f[11:7]);
        end
        dbl = {base, base} >> amt;
        v   = dbl[31:0];
        c   = (amt == 0) ? cin : v[31];
    endfunction

    task automatic apply(input logic m, input logic [31:0] w, input logic cin);
        @(negedge clk);
        mode     = m;
        instr    = w;
        carry_in = cin;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] ev;
        logic        ec;
        logic        ef;
        logic [31:0] held_v;
        logic        held_c;

        rst      = 1'b1;
        in_valid = 1'b1;
        mode     = 1'b1;
        instr    = 32'h000030AB;
        carry_in = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset wins over a valid request
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
        check(imm_out == 32'h0, "R1 imm_out", imm_out, 32'h0);
        check(carry_out == 1'b0, "R1 carry_out", 32'(carry_out), 32'h0);
        check(unpredictable == 1'b0, "R1 flag", 32'(unpredictable), 32'h0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after reset", 32'(out_valid), 32'h0);

        // Hand-worked corner vectors
        for (int i = 0; i < 16; i++) begin
            apply(VEC[i][67], VEC[i][65:34], VEC[i][66]);
            check(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'h1);
            check(imm_out == VEC[i][33:2], VEC[i][67] ? "R4 R5 R7 value" : "R2 R10 value",
                  imm_out, VEC[i][33:2]);
            check(carry_out == VEC[i][1], VEC[i][67] ? "R6 R7 carry" : "R3 carry",
                  32'(carry_out), 32'(VEC[i][1]));
            check(unpredictable == VEC[i][0], "R8 flag",
                  32'(unpredictable), 32'(VEC[i][0]));
        end

        // Every field value, both encodings, both carry-in values, junk elsewhere
        for (int m = 0; m < 2; m++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int f = 0; f < 4096; f++) begin
                    logic [11:0] f12;
                    logic [31:0] junk;
                    logic [31:0] w;
                    f12  = 12'(f);
                    junk = (32'(f) * 32'h9E3779B1) ^ 32'(m * 32'h5A5A0000 + ci);
                    if (m == 0)
                        w = {junk[31:12], f12};
                    else
                        w = (junk & 32'hFBFF8F00) |
                            {5'b0, f12[11], 11'b0, f12[10:8], 4'b0, f12[7:0]};
                    model(1'(m), w, 1'(ci), ev, ec, ef);
                    apply(1'(m), w, 1'(ci));
                    if (m == 0) begin
                        check(imm_out == ev, "R2 R10 sweep value", imm_out, ev);
                        check(carry_out == ec, "R3 sweep carry", 32'(carry_out), 32'(ec));
                    end else if (f12[11:10] == 2'b00) begin
                        check(imm_out == ev, "R4 R5 sweep value", imm_out, ev);
                        check(carry_out == ec, "R6 sweep carry", 32'(carry_out), 32'(ec));
                    end else begin
                        check(imm_out == ev, "R4 R7 sweep value", imm_out, ev);
                        check(carry_out == ec, "R7 sweep carry", 32'(carry_out), 32'(ec));
                    end
                    check(unpredictable == ef, "R8 sweep flag",
                          32'(unpredictable), 32'(ef));
                end
            end
        end

        // R9: outputs hold while no request is made
        apply(1'b1, 32'h000010AB, 1'b1);
        held_v = imm_out;
        held_c = carry_out;
        @(negedge clk);
        in_valid = 1'b0;
        mode     = 1'b0;
        instr    = 32'hFFFFFF00;
        carry_in = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid drops", 32'(out_valid), 32'h0);
        check(imm_out == held_v, "R9 value held", imm_out, held_v);
        check(carry_out == held_c, "R9 carry held", 32'(carry_out), 32'(held_c));
        @(negedge clk);
        check(imm_out == 32'h00AB00AB, "R9 value still held", imm_out, 32'h00AB00AB);

        // R1: reset in mid-run with a request pending
        apply(1'b1, 32'h00003000, 1'b1);
        check(unpredictable == 1'b1, "R8 flag before reset", 32'(unpredictable), 32'h1);
        rst      = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 mid-run valid", 32'(out_valid), 32'h0);
        check(carry_out == 1'b0, "R1 mid-run carry", 32'(carry_out), 32'h0);
        check(unpredictable == 1'b0, "R1 mid-run flag", 32'(unpredictable), 32'h0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        summary();
        $finish;
    end
endmodule